// File: doc/BRIEF.md
# Reloading Down-Counter Tick Timer

This block is one periodic timer channel, reached through a small word-indexed register bus. Software puts a period value into a reload register and into the live count, picks a clock prescale and whether the interrupt is enabled, and then sets the run bit in the start register. While the channel runs, the count drops by one on every prescaled tick. A tick that finds the count at zero puts the reload value back into the count and sets a sticky underflow flag.

The interrupt line is a level. It stays high while the flag is set and the enable bit is on. The flag can only be cleared: software writes the control register with the flag bit at zero, and writing a one to that bit changes nothing. Any write to the count lands on the next cycle, even while the channel is running, and it takes priority over that cycle's decrement.

Top module: `tmr_tick_timer`

## Requirements
- R1: A synchronous reset clears the run bit, the reload value, the count, the prescale select, the interrupt enable and the flag, and forces `irq` low.
- R2: The start register (word 0) runs the channel when bit 0 of the written value is 1 and stops it when that bit is 0. The other written bits are ignored and read back as zero. While stopped, the count holds its value.
- R3: Control bits 2:0 select the prescale: 0 divides by 4, 1 by 16, 2 by 64, and any value from 3 to 7 by 256. After a start, the first decrement occurs exactly one division period after the start write's clock edge.
- R4: A tick that finds the count at 0 loads the reload value (word 1) into the count on that tick and sets the flag, control bit 8.
- R5: Writing the control register (word 3) with bit 8 at 0 clears the flag. Writing it with bit 8 at 1 leaves the flag unchanged and can never set it.
- R6: `irq` is high exactly while the flag and the interrupt enable (control bit 5) are both 1, and it stays high until one of them is cleared.
- R7: A write to the count (word 2) appears in the count on the next cycle. It overrides a decrement or reload in that same cycle, and in that case the flag is not set.
- R8: When an underflow and a flag-clearing control write occur in the same cycle, the flag ends up set.
- R9: Reads are combinational. Word 1 and word 2 return all 32 bits. Word 3 returns the flag at bit 8, the enable at bit 5 and the select at bits 2:0, with every other bit zero.
- R10: Stopping the channel discards any partial prescale period, so after a restart a full division period passes before the next decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_word | input | 2 | Register index: 0 start, 1 reload, 2 count, 3 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Underflow interrupt level |

## Verification
Two pairs of events can land on the same clock edge. One pair is an underflow and a flag-clearing control write. The other is an underflow and a software write to the count. The bench provokes each pair by starting from a count of zero with the divide-by-4 prescale, then timing the write so that it sits on the fourth edge after the start edge. It judges the outcome by reading back the flag and the count. A behavioural reference model also follows the count, the flag and `irq` on every clock, across all prescale settings.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W    = 8;
    localparam int CTRL_W   = 16;
    localparam int SEL_W    = 3;
    localparam int FLAG_BIT = 8;
    localparam int IE_BIT   = 5;

    typedef enum logic [1:0] {
        REG_START  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_CTRL   = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic             flag;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    // Mask of prescaler bits that must all be one for a tick.
    function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        int stage;
        stage = (sel > 3'd3) ? 3 : int'(sel);
        return PRE_W'((1 << (2 * stage + 2)) - 1);
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
        logic [CTRL_W-1:0] v;
        v               = '0;
        v[FLAG_BIT]     = c.flag;
        v[IE_BIT]       = c.ie;
        v[SEL_W-1:0]    = c.sel;
        return v;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(sel);
    assign tick = run && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_word,
    input  logic [CNT_W-1:0] bus_wdata,
    input  logic             uf_set,
    output logic             run,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload,
    output logic             cnt_wr
);

    logic wr_start, wr_reload, wr_ctrl;

    assign wr_start  = bus_wr && (reg_idx_e'(bus_word) == REG_START);
    assign wr_reload = bus_wr && (reg_idx_e'(bus_word) == REG_RELOAD);
    assign wr_ctrl   = bus_wr && (reg_idx_e'(bus_word) == REG_CTRL);
    assign cnt_wr    = bus_wr && (reg_idx_e'(bus_word) == REG_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            reload <= '0;
            ctrl   <= '0;
        end else begin
            if (wr_start) begin
                run <= bus_wdata[0];
            end
            if (wr_reload) begin
                reload <= bus_wdata;
            end
            if (wr_ctrl) begin
                ctrl.ie  <= bus_wdata[IE_BIT];
                ctrl.sel <= bus_wdata[SEL_W-1:0];
            end
            // hardware set outranks a software clear in the same cycle
            if (uf_set) begin
                ctrl.flag <= 1'b1;
            end else if (wr_ctrl && !bus_wdata[FLAG_BIT]) begin
                ctrl.flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             uf
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign uf      = tick && at_zero && !cnt_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= wdata;
        end else if (tick) begin
            count <= at_zero ? reload : count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/tmr_tick_timer.sv
module tmr_tick_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_word,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    logic             run_w;
    logic             tick_w;
    logic             cnt_wr_w;
    logic             uf_w;
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    logic             flag_w;
    logic             ie_w;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_word (bus_word),
        .bus_wdata(bus_wdata),
        .uf_set   (uf_w),
        .run      (run_w),
        .ctrl     (ctrl_w),
        .reload   (reload_w),
        .cnt_wr   (cnt_wr_w)
    );

    tmr_prescale u_pre (
        .clk (clk),
        .rst (rst),
        .run (run_w),
        .sel (ctrl_w.sel),
        .tick(tick_w)
    );

    tmr_down #(.CNT_W(CNT_W)) u_down (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_w),
        .cnt_wr(cnt_wr_w),
        .wdata (bus_wdata),
        .reload(reload_w),
        .count (count_w),
        .uf    (uf_w)
    );

    assign flag_w = ctrl_w.flag;
    assign ie_w   = ctrl_w.ie;
    assign irq    = flag_w && ie_w;

    always_comb begin
        case (reg_idx_e'(bus_word))
            REG_START:  bus_rdata = {{(CNT_W-1){1'b0}}, run_w};
            REG_RELOAD: bus_rdata = reload_w;
            REG_COUNT:  bus_rdata = count_w;
            default:    bus_rdata = CNT_W'(ctrl_pack(ctrl_w));
        endcase
    end

endmodule

// File: rtl/tmr_tick_timer_chk.sv
module tmr_tick_timer_chk #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             irq,
    input  logic             run,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             uf,
    input  logic             flag,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] reload,
    input  logic             bus_wr,
    input  logic [1:0]       bus_word,
    input  logic [CNT_W-1:0] bus_wdata
);

    logic ctrl_wr, clr_wr;
    assign ctrl_wr = bus_wr && (bus_word == 2'd3);
    assign clr_wr  = ctrl_wr && !bus_wdata[8];

    a_r1_irq_low_after_reset: assert property (@(posedge clk)
        rst |=> !irq);

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(count));

    a_r3_tick_only_running: assert property (@(posedge clk) disable iff (rst)
        tick |-> run);

    a_r4_reload_on_underflow: assert property (@(posedge clk) disable iff (rst)
        uf |=> (count == $past(reload) && flag));

    a_r5_flag_rises_from_underflow: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(uf));

    a_r6_irq_held_without_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl_wr) |=> irq);

    a_r7_count_write_wins: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count == $past(bus_wdata)));

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (uf && clr_wr) |=> flag);

endmodule

bind tmr_tick_timer tmr_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .run      (run_w),
    .tick     (tick_w),
    .cnt_wr   (cnt_wr_w),
    .uf       (uf_w),
    .flag     (flag_w),
    .count    (count_w),
    .reload   (reload_w),
    .bus_wr   (bus_wr),
    .bus_word (bus_word),
    .bus_wdata(bus_wdata)
);

// File: tb/tmr_tick_timer_tb.sv
module tmr_tick_timer_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_word = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state
    logic        m_run = 1'b0;
    logic [31:0] m_reload = '0;
    logic [31:0] m_count = '0;
    logic        m_flag = 1'b0;
    logic        m_ie = 1'b0;
    logic [2:0]  m_sel = '0;
    int          m_pre = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_tick_timer u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_word (bus_word),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    function automatic int div_of(input logic [2:0] s);
        if (s == 3'd0) return 4;
        if (s == 3'd1) return 16;
        if (s == 3'd2) return 64;
        return 256;
    endfunction

    // behavioural model: advances once per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_reload = 0; m_count = 0; m_flag = 0;
            m_ie = 0; m_sel = 0; m_pre = 0;
        end else begin
            bit do_tick, wr_cnt, underflow;
            int d;
            d         = div_of(m_sel);
            do_tick   = m_run && ((m_pre % d) == d - 1);
            wr_cnt    = bus_wr && bus_word == 2'd2;
            underflow = do_tick && !wr_cnt && m_count == 0;
            m_pre     = m_run ? (m_pre + 1) % 256 : 0;
            if (wr_cnt) m_count = bus_wdata;
            else if (do_tick) m_count = (m_count == 0) ? m_reload : m_count - 1;
            if (underflow) m_flag = 1;
            else if (bus_wr && bus_word == 2'd3 && !bus_wdata[8]) m_flag = 0;
            if (bus_wr && bus_word == 2'd3) begin
                m_ie  = bus_wdata[5];
                m_sel = bus_wdata[2:0];
            end
            if (bus_wr && bus_word == 2'd1) m_reload = bus_wdata;
            if (bus_wr && bus_word == 2'd0) m_run = bus_wdata[0];
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] w);
        case (w)
            2'd0:    return {31'b0, m_run};
            2'd1:    return m_reload;
            2'd2:    return m_count;
            default: return {23'b0, m_flag, 2'b0, m_ie, 2'b0, m_sel};
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            logic [31:0] exp;
            exp = model_read(bus_word);
            n_checks++;
            if (bus_rdata !== exp) begin
                n_fails++;
                $display("FAIL R9 model readback word %0d: got %h expected %h", bus_word, bus_rdata, exp);
            end
            n_checks++;
            if (irq !== (m_flag && m_ie)) begin
                n_fails++;
                $display("FAIL R6 model irq: got %b expected %b", irq, m_flag && m_ie);
            end
        end
    end

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        #1;
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        #1;
        bus_wr = 1'b0; bus_word = 2'd2;
    endtask

    task automatic peek(input logic [1:0] w, input logic [31:0] exp, input string tag);
        bus_word = w;
        #1;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, bus_rdata, exp);
        end
        bus_word = 2'd2;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        n_checks++;
        if (irq !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        peek(2'd0, 32'h0, "R1 start after reset");
        peek(2'd1, 32'h0, "R1 reload after reset");
        peek(2'd2, 32'h0, "R1 count after reset");
        peek(2'd3, 32'h0, "R1 control after reset");
        check_irq(1'b0, "R1 irq after reset");

        // basic periodic run, divide by 4, interrupt enabled
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd5);
        wr(2'd3, 32'h0020);
        wr(2'd0, 32'd1);
        for (int i = 0; i < 100 && irq !== 1'b1; i++) @(negedge clk);
        #1;
        peek(2'd2, 32'd5, "R4 count reloaded at underflow");
        peek(2'd3, 32'h0120, "R4 flag set at underflow");
        check_irq(1'b1, "R6 irq with flag and enable");
        repeat (60) @(negedge clk);

        // R5: flag survives a write with bit 8 set, then clears
        wr(2'd0, 32'd0);
        wr(2'd3, 32'h0120);
        peek(2'd3, 32'h0120, "R5 write one keeps flag");
        check_irq(1'b1, "R6 irq held");
        wr(2'd3, 32'h0020);
        peek(2'd3, 32'h0020, "R5 write zero clears flag");
        check_irq(1'b0, "R6 irq drops with flag");
        wr(2'd3, 32'h0120);
        peek(2'd3, 32'h0020, "R5 write one does not set flag");

        // R2: stopped count holds; start bits above 0 ignored
        bus_word = 2'd2; #1; held = bus_rdata;
        repeat (40) @(negedge clk);
        #1;
        peek(2'd2, held, "R2 count holds while stopped");
        wr(2'd0, 32'hFE);
        peek(2'd0, 32'h0, "R2 start bit0 zero stops");
        repeat (20) @(negedge clk);
        #1;
        peek(2'd2, held, "R2 count holds after 0xFE start write");
        wr(2'd0, 32'h3);
        peek(2'd0, 32'h1, "R2 start reads only bit0");
        wr(2'd0, 32'h0);

        // R9: readback formats
        wr(2'd1, 32'hDEADBEEF);
        peek(2'd1, 32'hDEADBEEF, "R9 reload full width");
        wr(2'd3, 32'h0000FFFF);
        peek(2'd3, 32'h0027, "R9 control field layout");

        // R3 and R10: divide by 16 timing, restart after stop
        wr(2'd2, 32'd100);
        wr(2'd3, 32'h0021);
        wr(2'd0, 32'd1);
        repeat (15) @(negedge clk);
        #1;
        peek(2'd2, 32'd100, "R3 no decrement before 16 clocks");
        @(negedge clk); #1;
        peek(2'd2, 32'd99, "R3 decrement after 16 clocks");
        repeat (7) @(negedge clk);
        wr(2'd0, 32'd0);
        wr(2'd0, 32'd1);
        repeat (15) @(negedge clk);
        #1;
        peek(2'd2, 32'd99, "R10 partial period discarded");
        @(negedge clk); #1;
        peek(2'd2, 32'd98, "R10 full period after restart");

        // R6: flag without enable keeps irq low
        wr(2'd0, 32'd0);
        wr(2'd3, 32'h0000);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd7);
        wr(2'd0, 32'd1);
        repeat (6) @(negedge clk);
        #1;
        peek(2'd3, 32'h0100, "R4 flag set with enable off");
        check_irq(1'b0, "R6 irq low with enable off");
        wr(2'd3, 32'h0120);
        check_irq(1'b1, "R6 irq rises when enable set");

        // R3: other prescale settings, model-compared
        wr(2'd0, 32'd0);
        wr(2'd3, 32'h0022);
        wr(2'd2, 32'd3);
        wr(2'd1, 32'd2);
        wr(2'd0, 32'd1);
        repeat (700) @(negedge clk);
        wr(2'd3, 32'h0023);
        repeat (2000) @(negedge clk);
        wr(2'd3, 32'h0027);
        repeat (2000) @(negedge clk);

        // R8: underflow and clearing write on the same edge
        wr(2'd0, 32'd0);
        wr(2'd3, 32'h0020);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        repeat (2) @(negedge clk);
        wr(2'd3, 32'h0020);
        peek(2'd3, 32'h0120, "R8 set beats clear");
        peek(2'd2, 32'd3, "R8 reload on colliding tick");

        // R7: count write on the underflow edge
        wr(2'd0, 32'd0);
        wr(2'd3, 32'h0020);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        repeat (2) @(negedge clk);
        wr(2'd2, 32'd50);
        peek(2'd2, 32'd50, "R7 write overrides reload");
        peek(2'd3, 32'h0020, "R7 no flag when write wins");
        repeat (300) @(negedge clk);
        wr(2'd2, 32'd9);
        repeat (100) @(negedge clk);

        finish_run();
    end

endmodule